// File: doc/BRIEF.md
# ADC Control Register Front End with Power Sequencer

This block sits between a simple 32-bit register bus and one successive-approximation converter. Software uses it to bring the converter out of its lowest power state, turn on its internal regulator, enable it, choose a channel and launch single conversions. The front end enforces the power-up order in hardware. A control write can only move the block one stage further: deep power-down, then off, then regulator settling, then regulator on, then enable settling, then ready. Each settling stage lasts a parameterised number of clock cycles.

A conversion starts only when the block is fully ready and the requested channel is set in the preselection mask. The converter itself is modelled by a stub. While it is busy it shows the selected channel on `conv_chan` and raises `conv_active`. At the end of the conversion time it captures the 16-bit value on `conv_sample` into the data register and raises end of conversion. Software polls the status word and then reads the data word, which clears the flag. The register bus has no back-pressure: every access completes in the cycle it is presented, and read data is combinational from the address.

Top module: `adcfe_top`

## Requirements
- R1: After reset, status (offset 0x00) reads 0 and control (offset 0x08) reads 0x2000_0000, which means only the deep power-down bit 29 is set.
- R2: A control write with bit 29 set always enters deep power-down. In the same write it clears regulator enable (bit 28), boost (bit 8), enable (bit 0), regulator-ready (status bit 12) and ready (status bit 0).
- R3: A control write with bit 29 clear, made while in deep power-down, only leaves deep power-down. Regulator enable in that same write is ignored, so control reads 0 and regulator-ready stays 0 from then on.
- R4: A control write with bit 28 set, made while powered up but off, sets control bit 28. Status bit 12 (regulator-ready) rises exactly REG_DLY clock cycles after that write.
- R5: Enable (control bit 0) is ignored until regulator-ready is set. Once accepted, control bit 0 reads 1 and status bit 0 (ready) rises exactly EN_DLY cycles after the write.
- R6: When ready, a control write with bit 2 set starts a conversion of the channel held in sequence bits 10:6 (offset 0x30), provided that channel's bit is set in the preselect mask (offset 0x1C). Status bit 2 rises exactly CONV_CYC cycles after the write. Offset 0x40 then returns the sample that was present for that channel.
- R7: A read of the data register (offset 0x40) clears status bit 2.
- R8: A start request is ignored when the block is not ready, when the channel's preselect bit is clear, or when the channel number is 20 or above. It raises no end of conversion and leaves the data register unchanged.
- R9: A control write with bit 1 set, made while enabling or ready, clears ready and control bit 0. Regulator-ready stays set.
- R10: These registers read back only their kept bits, and every other bit reads 0:
  - configuration (0x0C): bits 11:10 and 1:0
  - sample-time words (0x14, 0x18): bits 29:0
  - preselect (0x1C) and differential select (0xC0): bits 19:0
  - sequence (0x30): bits 10:6 and 3:0
- R11: A control write with both bit 28 and bit 29 clear, made outside deep power-down, switches the regulator off. Status then reads 0 and control reads 0.
- R12: Boost (control bit 8) reads back as last written whenever the write leaves deep power-down clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| conv_chan | output | 5 | Channel the converter stub samples |
| conv_active | output | 1 | Conversion in progress |
| conv_sample | input | 16 | Value the converter returns for conv_chan |

## Verification
On every cycle, the assertions check the following:
- deep power-down is always reachable in one write;
- deep power-down is left only towards the off state;
- enable settling and regulator-on are entered only from their legal predecessors;
- end of conversion rises only from a running conversion;
- a data read clears the flag;
- a conversion never begins for an unselected channel or outside the ready state.

The exact settling and conversion latencies, and the captured sample values for random channels and masks, can only be shown by the bench's scenarios. The same holds for the register readback masks and the ordering rules of the staged power-up.

// File: rtl/adcfe_pkg.sv
package adcfe_pkg;
  typedef enum logic [2:0] {
    PW_DEEP, PW_OFF, PW_REGWAIT, PW_REGON, PW_ENWAIT, PW_READY
  } pwr_state_e;

  localparam logic [7:0] OFS_STATUS = 8'h00;
  localparam logic [7:0] OFS_CTRL   = 8'h08;
  localparam logic [7:0] OFS_CFG    = 8'h0C;
  localparam logic [7:0] OFS_SMP1   = 8'h14;
  localparam logic [7:0] OFS_SMP2   = 8'h18;
  localparam logic [7:0] OFS_PRESEL = 8'h1C;
  localparam logic [7:0] OFS_SEQ    = 8'h30;
  localparam logic [7:0] OFS_DATA   = 8'h40;
  localparam logic [7:0] OFS_DIFF   = 8'hC0;

  localparam int CB_EN    = 0;
  localparam int CB_DIS   = 1;
  localparam int CB_START = 2;
  localparam int CB_BOOST = 8;
  localparam int CB_REGEN = 28;
  localparam int CB_DEEP  = 29;

  localparam int SB_RDY    = 0;
  localparam int SB_EOC    = 2;
  localparam int SB_REGRDY = 12;

  localparam int SEQ_CH_LSB = 6;
  localparam int SEQ_LEN_W  = 4;
  localparam int SMP_W      = 30;
endpackage

// File: rtl/adcfe_power.sv
module adcfe_power
  import adcfe_pkg::*;
#(
  parameter int REG_DLY = 40,
  parameter int EN_DLY  = 20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_wr,
  input  logic       w_deep,
  input  logic       w_regen,
  input  logic       w_en,
  input  logic       w_dis,
  output pwr_state_e state
);
  localparam int MAXD  = (REG_DLY > EN_DLY) ? REG_DLY : EN_DLY;
  localparam int CNT_W = $clog2(MAXD + 1);

  pwr_state_e nxt;
  logic [CNT_W-1:0] cnt;

  always_comb begin
    nxt = state;
    case (state)
      PW_REGWAIT: if (cnt == CNT_W'(REG_DLY - 1)) nxt = PW_REGON;
      PW_ENWAIT:  if (cnt == CNT_W'(EN_DLY - 1))  nxt = PW_READY;
      default: ;
    endcase
    if (ctl_wr) begin
      if (w_deep)                nxt = PW_DEEP;
      else if (state == PW_DEEP) nxt = PW_OFF;
      else if (!w_regen)         nxt = PW_OFF;
      else begin
        case (state)
          PW_OFF:   nxt = PW_REGWAIT;
          PW_REGON: if (w_en) nxt = PW_ENWAIT;
          PW_ENWAIT, PW_READY: if (w_dis) nxt = PW_REGON;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PW_DEEP;
      cnt   <= '0;
    end else begin
      state <= nxt;
      if (nxt != state) cnt <= '0;
      else if (state == PW_REGWAIT || state == PW_ENWAIT) cnt <= cnt + 1'b1;
    end
  end

  assert_deep_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && w_deep) |=> (state == PW_DEEP));

  assert_leave_deep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == PW_DEEP && state != PW_DEEP) |-> (state == PW_OFF));

  assert_regon_pred_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PW_REGON) |-> ($past(state) inside {PW_REGWAIT, PW_REGON, PW_ENWAIT, PW_READY}));

  assert_staged_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PW_ENWAIT && $past(state) != PW_ENWAIT) |-> ($past(state) == PW_REGON));
endmodule

// File: rtl/adcfe_conv.sv
module adcfe_conv #(
  parameter int CONV_CYC = 16,
  parameter int DATA_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adc_ready,
  input  logic              start_ok,
  input  logic              data_rd,
  input  logic [DATA_W-1:0] sample_in,
  output logic              busy,
  output logic              eoc,
  output logic [DATA_W-1:0] data_q
);
  localparam int CNT_W = $clog2(CONV_CYC + 1);

  logic [CNT_W-1:0] cnt;
  logic             done;

  assign done = busy && adc_ready && (cnt == CNT_W'(CONV_CYC - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      eoc    <= 1'b0;
      data_q <= '0;
    end else begin
      if (!busy) begin
        if (start_ok && adc_ready) begin
          busy <= 1'b1;
          cnt  <= '0;
        end
      end else if (!adc_ready || done) begin
        busy <= 1'b0;
      end else begin
        cnt <= cnt + 1'b1;
      end
      if (done) begin
        eoc    <= 1'b1;
        data_q <= sample_in;
      end else if (data_rd) begin
        eoc <= 1'b0;
      end
    end
  end

  assert_eoc_from_conv_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(eoc) |-> $past(busy));

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !busy) |=> !eoc);

  assert_start_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(adc_ready && start_ok));
endmodule

// File: rtl/adcfe_top.sv
module adcfe_top
  import adcfe_pkg::*;
#(
  parameter int NUM_CH   = 20,
  parameter int DATA_W   = 16,
  parameter int REG_DLY  = 40,
  parameter int EN_DLY   = 20,
  parameter int CONV_CYC = 16,
  localparam int CH_W    = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [7:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic [CH_W-1:0]   conv_chan,
  output logic              conv_active,
  input  logic [DATA_W-1:0] conv_sample
);
  localparam int MASK_W = 1 << CH_W;

  pwr_state_e       pw_state;
  logic             wr_any, ctl_wr, start_ok, data_rd;
  logic             conv_eoc;
  logic [DATA_W-1:0] data_q;
  logic [3:0]       cfg_q;
  logic [SMP_W-1:0] smp_q [2];
  logic [NUM_CH-1:0] presel_q, diff_q;
  logic [MASK_W-1:0] presel_ext;
  logic [CH_W-1:0]  seq_ch_q;
  logic [SEQ_LEN_W-1:0] seq_len_q;
  logic             boost_q;
  logic             st_ready, st_regrdy, st_en, st_regen;
  logic             unused_wbits;

  assign unused_wbits = ^bus_wdata[31:30];

  assign wr_any  = bus_sel && bus_wr;
  assign ctl_wr  = wr_any && (bus_addr == OFS_CTRL);
  assign data_rd = bus_sel && !bus_wr && (bus_addr == OFS_DATA);
  assign presel_ext = MASK_W'(presel_q);
  assign start_ok = ctl_wr && bus_wdata[CB_START] && bus_wdata[CB_REGEN] &&
                    !bus_wdata[CB_DEEP] && !bus_wdata[CB_DIS] && presel_ext[seq_ch_q];

  assign st_ready  = (pw_state == PW_READY);
  assign st_regrdy = pw_state inside {PW_REGON, PW_ENWAIT, PW_READY};
  assign st_en     = pw_state inside {PW_ENWAIT, PW_READY};
  assign st_regen  = pw_state inside {PW_REGWAIT, PW_REGON, PW_ENWAIT, PW_READY};

  adcfe_power #(.REG_DLY(REG_DLY), .EN_DLY(EN_DLY)) u_power (
    .clk     (clk),
    .rst_n   (rst_n),
    .ctl_wr  (ctl_wr),
    .w_deep  (bus_wdata[CB_DEEP]),
    .w_regen (bus_wdata[CB_REGEN]),
    .w_en    (bus_wdata[CB_EN]),
    .w_dis   (bus_wdata[CB_DIS]),
    .state   (pw_state)
  );

  adcfe_conv #(.CONV_CYC(CONV_CYC), .DATA_W(DATA_W)) u_conv (
    .clk       (clk),
    .rst_n     (rst_n),
    .adc_ready (st_ready),
    .start_ok  (start_ok),
    .data_rd   (data_rd),
    .sample_in (conv_sample),
    .busy      (conv_active),
    .eoc       (conv_eoc),
    .data_q    (data_q)
  );

  assign conv_chan = seq_ch_q;

  // Two sample-time words share one layout
  for (genvar gi = 0; gi < 2; gi++) begin : g_smp
    localparam logic [7:0] OFS = (gi == 0) ? OFS_SMP1 : OFS_SMP2;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) smp_q[gi] <= '0;
      else if (wr_any && bus_addr == OFS) smp_q[gi] <= bus_wdata[SMP_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      presel_q  <= '0;
      diff_q    <= '0;
      seq_ch_q  <= '0;
      seq_len_q <= '0;
      boost_q   <= 1'b0;
    end else if (wr_any) begin
      case (bus_addr)
        OFS_CFG:    cfg_q    <= {bus_wdata[11:10], bus_wdata[1:0]};
        OFS_PRESEL: presel_q <= bus_wdata[NUM_CH-1:0];
        OFS_DIFF:   diff_q   <= bus_wdata[NUM_CH-1:0];
        OFS_SEQ: begin
          seq_ch_q  <= bus_wdata[SEQ_CH_LSB +: CH_W];
          seq_len_q <= bus_wdata[SEQ_LEN_W-1:0];
        end
        OFS_CTRL:   boost_q  <= bus_wdata[CB_BOOST] && !bus_wdata[CB_DEEP];
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_STATUS: begin
        bus_rdata[SB_RDY]    = st_ready;
        bus_rdata[SB_EOC]    = conv_eoc;
        bus_rdata[SB_REGRDY] = st_regrdy;
      end
      OFS_CTRL: begin
        bus_rdata[CB_EN]    = st_en;
        bus_rdata[CB_START] = conv_active;
        bus_rdata[CB_BOOST] = boost_q;
        bus_rdata[CB_REGEN] = st_regen;
        bus_rdata[CB_DEEP]  = (pw_state == PW_DEEP);
      end
      OFS_CFG:    bus_rdata = {20'd0, cfg_q[3:2], 8'd0, cfg_q[1:0]};
      OFS_SMP1:   bus_rdata = 32'(smp_q[0]);
      OFS_SMP2:   bus_rdata = 32'(smp_q[1]);
      OFS_PRESEL: bus_rdata = 32'(presel_q);
      OFS_DIFF:   bus_rdata = 32'(diff_q);
      OFS_SEQ: begin
        bus_rdata[SEQ_CH_LSB +: CH_W]  = seq_ch_q;
        bus_rdata[SEQ_LEN_W-1:0]       = seq_len_q;
      end
      OFS_DATA:   bus_rdata = 32'(data_q);
      default: ;
    endcase
  end

  assert_unselected_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && bus_wdata[CB_START] && !presel_ext[seq_ch_q] && !conv_active) |=> !conv_active);

  assert_deep_no_boost_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && bus_wdata[CB_DEEP]) |=> (!boost_q && !st_regrdy));
endmodule

// File: tb/adcfe_top_bench.sv
module adcfe_top_bench;
  localparam int REG_DLY  = 8;
  localparam int EN_DLY   = 6;
  localparam int CONV_CYC = 5;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [4:0]  conv_chan;
  logic        conv_active;
  logic [15:0] conv_sample;
  logic [15:0] salt = 16'h5a3c;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  function automatic logic [15:0] sample_of(input int ch, input logic [15:0] s);
    return 16'(ch * 16'h0f1d) ^ s;
  endfunction

  always_comb conv_sample = sample_of(int'(conv_chan), salt);

  adcfe_top #(.REG_DLY(REG_DLY), .EN_DLY(EN_DLY), .CONV_CYC(CONV_CYC)) u_adcfe_top (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .conv_chan(conv_chan), .conv_active(conv_active), .conv_sample(conv_sample)
  );

  task automatic check(input logic [31:0] got, input logic [31:0] exp, input string tag);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk); @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    logic [31:0] v, r, last_data;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(8'h00, v); check(v, 32'h0, "R1 status after reset");
    rd(8'h08, v); check(v, 32'h2000_0000, "R1 control after reset");

    wr(8'h08, 32'h1000_0000);
    rd(8'h08, v); check(v, 32'h0, "R3 regen ignored when leaving deep");
    idle(REG_DLY + 2);
    rd(8'h00, v); check(v, 32'h0, "R3 no regulator-ready");

    wr(8'h08, 32'h1000_0001);
    idle(REG_DLY - 1);
    rd(8'h00, v); check(v, 32'h0, "R4 regulator-ready not early");
    rd(8'h00, v); check(v, 32'h0000_1000, "R4 regulator-ready on time");
    rd(8'h08, v); check(v, 32'h1000_0000, "R5 enable ignored while settling");

    wr(8'h08, 32'h1000_0001);
    idle(EN_DLY - 1);
    rd(8'h00, v); check(v, 32'h0000_1000, "R5 ready not early");
    rd(8'h00, v); check(v, 32'h0000_1001, "R5 ready on time");

    last_data = 32'h0;
    for (int i = 0; i < 14; i++) begin
      int ch;
      logic [19:0] mask;
      bit valid;
      ch = $urandom_range(0, 21);
      mask = 20'($urandom);
      if (ch < 20) mask[ch] = (i % 3 != 2);
      salt = 16'($urandom);
      valid = (ch < 20) && mask[ch];
      wr(8'h1C, 32'(mask));
      wr(8'h30, 32'(ch) << 6);
      wr(8'h08, 32'h1000_0005);
      if (valid) begin
        idle(CONV_CYC - 1);
        rd(8'h00, v); check(v, 32'h0000_1001, "R6 eoc not early");
        rd(8'h00, v); check(v, 32'h0000_1005, "R6 eoc on time");
        rd(8'h40, v); check(v, 32'(sample_of(ch, salt)), "R6 sample value");
        last_data = v;
        rd(8'h00, v); check(v, 32'h0000_1001, "R7 data read clears eoc");
      end else begin
        idle(CONV_CYC + 2);
        rd(8'h00, v); check(v, 32'h0000_1001, "R8 unselected channel no eoc");
        rd(8'h40, v); check(v, last_data, "R8 data unchanged");
      end
    end

    wr(8'h08, 32'h1000_0003);
    rd(8'h00, v); check(v, 32'h0000_1000, "R9 disable keeps regulator");
    rd(8'h08, v); check(v, 32'h1000_0000, "R9 enable bit cleared");
    wr(8'h1C, 32'h000F_FFFF);
    wr(8'h30, 32'd3 << 6);
    wr(8'h08, 32'h1000_0004);
    idle(CONV_CYC + 2);
    rd(8'h00, v); check(v, 32'h0000_1000, "R8 start when not ready");
    rd(8'h40, v); check(v, last_data, "R8 data unchanged when not ready");

    wr(8'h08, 32'h1000_0101);
    rd(8'h08, v); check(v, 32'h1000_0101, "R12 boost readback");
    idle(EN_DLY + 1);
    rd(8'h00, v); check(v, 32'h0000_1001, "R5 ready again");

    wr(8'h08, 32'h2000_0101);
    rd(8'h08, v); check(v, 32'h2000_0000, "R2 deep clears regen boost enable");
    rd(8'h00, v); check(v, 32'h0, "R2 deep clears flags");

    wr(8'h08, 32'h0);
    wr(8'h08, 32'h1000_0000);
    idle(REG_DLY + 1);
    rd(8'h00, v); check(v, 32'h0000_1000, "R11 regulator up");
    wr(8'h08, 32'h0);
    rd(8'h00, v); check(v, 32'h0, "R11 status after regulator off");
    rd(8'h08, v); check(v, 32'h0, "R11 control after regulator off");

    for (int k = 0; k < 3; k++) begin
      r = $urandom; wr(8'h0C, r); rd(8'h0C, v); check(v, r & 32'h0000_0C03, "R10 configuration");
      r = $urandom; wr(8'h14, r); rd(8'h14, v); check(v, r & 32'h3FFF_FFFF, "R10 sample-time 1");
      r = $urandom; wr(8'h18, r); rd(8'h18, v); check(v, r & 32'h3FFF_FFFF, "R10 sample-time 2");
      r = $urandom; wr(8'h1C, r); rd(8'h1C, v); check(v, r & 32'h000F_FFFF, "R10 preselect");
      r = $urandom; wr(8'h30, r); rd(8'h30, v); check(v, r & 32'h0000_07CF, "R10 sequence");
      r = $urandom; wr(8'hC0, r); rd(8'hC0, v); check(v, r & 32'h000F_FFFF, "R10 differential select");
    end

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule